// File: doc/BRIEF.md
# Phase-Offset Numerically Controlled Oscillator with Dither

This block is the local oscillator of one tuner channel. Every clock it adds a signed tuning word to a wrapping phase accumulator. It then adds a programmable phase offset and, when enabled, a small pseudo-random dither value. The upper bits of that sum address a quarter-wave sine table. The table is computed inside the design and folded by symmetry to give full-cycle cosine and sine samples.

The tuning word is two's complement, so negative frequencies tune below the carrier. The output frequency as a fraction of the clock rate is the word divided by 2^32. The phase offset is an unsigned turn fraction: 2π times the word over 2^16 radians. A one-cycle sync input restarts the accumulator at zero without touching the tuning or offset words. The channel can therefore be phase-aligned with a neighbour. The outputs are registered, signed 17-bit samples.

Top module: `tuner_nco`

## Requirements
- R1: While `rst` is high, both outputs are held at 0 and the accumulator is cleared. With zero words after release, the outputs settle to the table-index-0 values: cosine 65535, sine 201.
- R2: Each clock the accumulator adds `freq_i` modulo 2^32. Positive and negative (two's complement) words both advance the phase correctly.
- R3: `phase_i` is added to bits [31:16] of the accumulator value to form the phase sum. Its bit 15 carries half a turn.
- R4: For table index i = bits [31:22] of the phase sum, `sin_o` = round(65535·sin(2π(i+0.5)/1024)) and `cos_o` = round(65535·cos(2π(i+0.5)/1024)). Both are 17-bit two's complement, to within 1 LSB.
- R5: A change on `phase_i` before clock edge e shows on the outputs after edge e+2. An accumulator value captured at one edge shows on the outputs three edges later.
- R6: `sync_i` high at an edge loads the accumulator with 0 and keeps the tuning and offset words. The edge after that one forms a phase sum equal to the offset alone, and later sums advance by the tuning word again.
- R7: With `dith_en_i` low, no dither is added. With it high, a nonzero 6-bit pseudo-random value is added at bits [21:16], just below the table index.
- R8: With dither on, every output sample equals the table value for the undithered index or for the next index up.
- R9: Neither output ever leaves the range −65535 to +65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Clears the phase accumulator at the edge |
| freq_i | input | 32 | Signed tuning word |
| phase_i | input | 16 | Unsigned phase offset word |
| dith_en_i | input | 1 | Enables phase dither |
| cos_o | output | 17 | Cosine sample, two's complement |
| sin_o | output | 17 | Sine sample, two's complement |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 16-bit offset, a 256-entry quarter table (10-bit index), 17-bit outputs and 6-bit dither. With these values one index step is 2^22 accumulator counts. A phase offset of 0x003F then sits exactly one dither step below an index boundary. This makes the effect of dither deterministic at the ports, and it lets a real-valued reference confirm every quadrant fold to within 1 LSB. The accumulator wraps modulo 2^32, so the extreme tuning words 0x7FFFFFFF and 0x80000000 are reachable in a few cycles.

// File: rtl/tuner_nco_pkg.sv
package tuner_nco_pkg;

  typedef enum logic [1:0] {
    QUAD_0 = 2'd0,
    QUAD_1 = 2'd1,
    QUAD_2 = 2'd2,
    QUAD_3 = 2'd3
  } quad_e;

  localparam real TWO_PI = 6.283185307179586;

  // Round to nearest, halves away from zero.
  function automatic int round_near(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

endpackage

// File: rtl/tuner_nco_lfsr.sv
module tuner_nco_lfsr #(
  parameter int          W    = 6,
  parameter logic [W-1:0] TAPS = 6'b110000
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);

  logic [W-1:0] st_q;

  // Galois right-shift form; the top tap bit keeps the state nonzero.
  always_ff @(posedge clk) begin
    if (rst) st_q <= W'(1);
    else     st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  assign state_o = st_q;

endmodule

// File: rtl/tuner_nco_phase.sv
module tuner_nco_phase #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int DITH_W  = 6,
  parameter int DITH_SH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [DITH_W-1:0] dith_i,
  output logic [FREQ_W-1:0] acc_o,
  output logic [FREQ_W-1:0] sum_o
);

  localparam int OFF_SH = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0] acc_q, sum_q, off_ext, dith_ext;

  assign off_ext  = {phase_i, {OFF_SH{1'b0}}};
  assign dith_ext = FREQ_W'(dith_i) << DITH_SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sum_q <= '0;
    end else begin
      acc_q <= sync_i ? '0 : acc_q + freq_i;
      sum_q <= acc_q + off_ext + dith_ext;
    end
  end

  assign acc_o = acc_q;
  assign sum_o = sum_q;

endmodule

// File: rtl/tuner_nco_rom.sv
module tuner_nco_rom #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [MAG_W-1:0]  data_a,
  output logic [MAG_W-1:0]  data_b
);
  import tuner_nco_pkg::*;

  localparam int  DEPTH = 1 << ADDR_W;
  localparam real AMAX  = real'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] mem [DEPTH];

  // First quarter of a sine sampled at half-step offsets.
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = MAG_W'(round_near(AMAX * $sin(TWO_PI * (real'(k) + 0.5) / real'(4 * DEPTH))));
    end
  end

  always_ff @(posedge clk) begin
    data_a <= mem[addr_a];
    data_b <= mem[addr_b];
  end

endmodule

// File: rtl/tuner_nco.sv
module tuner_nco #(
  parameter int          FREQ_W    = 32,
  parameter int          PHASE_W   = 16,
  parameter int          ADDR_W    = 8,
  parameter int          AMP_W     = 17,
  parameter int          DITH_W    = 6,
  parameter logic [DITH_W-1:0] DITH_TAPS = 6'b110000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_i,
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               dith_en_i,
  output logic [AMP_W-1:0]   cos_o,
  output logic [AMP_W-1:0]   sin_o
);
  import tuner_nco_pkg::*;

  localparam int IDX_W   = ADDR_W + 2;
  localparam int MAG_W   = AMP_W - 1;
  localparam int DITH_SH = FREQ_W - IDX_W - DITH_W;

  logic [DITH_W-1:0] lfsr_w, dith_w;
  logic [FREQ_W-1:0] acc_w, sum_w;
  logic [IDX_W-1:0]  idx_w;
  logic [ADDR_W-1:0] fine_w;
  quad_e             quad_w, quad_q;
  logic [MAG_W-1:0]  mag_a, mag_b;

  tuner_nco_lfsr #(.W(DITH_W), .TAPS(DITH_TAPS)) u_lfsr (
    .clk(clk), .rst(rst), .state_o(lfsr_w)
  );

  assign dith_w = dith_en_i ? lfsr_w : '0;

  tuner_nco_phase #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .DITH_W(DITH_W), .DITH_SH(DITH_SH)
  ) u_phase (
    .clk(clk), .rst(rst), .sync_i(sync_i), .freq_i(freq_i),
    .phase_i(phase_i), .dith_i(dith_w), .acc_o(acc_w), .sum_o(sum_w)
  );

  assign idx_w  = sum_w[FREQ_W-1 -: IDX_W];
  assign quad_w = quad_e'(idx_w[IDX_W-1 -: 2]);
  assign fine_w = idx_w[ADDR_W-1:0];

  // Port A reads the rising-slope entry, port B the mirrored one.
  tuner_nco_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk(clk), .addr_a(fine_w), .addr_b(~fine_w),
    .data_a(mag_a), .data_b(mag_b)
  );

  always_ff @(posedge clk) begin
    if (rst) quad_q <= QUAD_0;
    else     quad_q <= quad_w;
  end

  logic [MAG_W-1:0] s_mag, c_mag;
  logic             s_neg, c_neg;
  logic [AMP_W-1:0] s_pos, c_pos;

  always_comb begin
    unique case (quad_q)
      QUAD_0:  begin s_mag = mag_a; s_neg = 1'b0; c_mag = mag_b; c_neg = 1'b0; end
      QUAD_1:  begin s_mag = mag_b; s_neg = 1'b0; c_mag = mag_a; c_neg = 1'b1; end
      QUAD_2:  begin s_mag = mag_a; s_neg = 1'b1; c_mag = mag_b; c_neg = 1'b1; end
      default: begin s_mag = mag_b; s_neg = 1'b1; c_mag = mag_a; c_neg = 1'b0; end
    endcase
    s_pos = {1'b0, s_mag};
    c_pos = {1'b0, c_mag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= s_neg ? -s_pos : s_pos;
      cos_o <= c_neg ? -c_pos : c_pos;
    end
  end

endmodule

// File: rtl/tuner_nco_chk.sv
module tuner_nco_chk #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 17,
  parameter int ADDR_W  = 8,
  parameter int DITH_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               sync_i,
  input logic               dith_en_i,
  input logic [FREQ_W-1:0]  freq_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic [FREQ_W-1:0]  acc,
  input logic [FREQ_W-1:0]  sum,
  input logic [AMP_W-1:0]   cos_o,
  input logic [AMP_W-1:0]   sin_o
);

  localparam int DITH_SH = FREQ_W - ADDR_W - 2 - DITH_W;
  localparam logic [FREQ_W-1:0] LIM = FREQ_W'(1) << (DITH_SH + DITH_W);
  localparam int MAXV = (1 << (AMP_W - 1)) - 1;

  logic [FREQ_W-1:0] base_q, diff;

  always_ff @(posedge clk) base_q <= acc + {phase_i, {(FREQ_W - PHASE_W){1'b0}}};
  assign diff = sum - base_q;

  a_r2_accumulate: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> acc == $past(acc) + $past(freq_i));

  a_r6_sync_clear: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> acc == '0);

  a_r7_dither_off: assert property (@(posedge clk) disable iff (rst)
    !dith_en_i |=> diff == '0);

  a_r8_dither_bounded: assert property (@(posedge clk) disable iff (rst)
    dith_en_i |=> (diff != '0) && (diff < LIM));

  a_r9_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(cos_o) >= -MAXV) && ($signed(sin_o) >= -MAXV));

endmodule

bind tuner_nco tuner_nco_chk #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .ADDR_W(ADDR_W), .DITH_W(DITH_W)
) u_chk (
  .clk(clk), .rst(rst), .sync_i(sync_i), .dith_en_i(dith_en_i),
  .freq_i(freq_i), .phase_i(phase_i), .acc(acc_w), .sum(sum_w),
  .cos_o(cos_o), .sin_o(sin_o)
);

// File: tb/sim_tuner_nco.sv
`timescale 1ns/1ps
module sim_tuner_nco;

  localparam int NIDX = 1024;
  localparam real AMAX = 65535.0;
  localparam int NVEC = 7;
  // {tuning word, phase offset}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0100_0000, 16'h0000},
    {32'hFF00_0000, 16'h0000},
    {32'h0012_3457, 16'h1234},
    {32'hFFED_CBA9, 16'h8000},
    {32'h7FFF_FFFF, 16'h4000},
    {32'h8000_0000, 16'hC000},
    {32'h0000_0001, 16'hFFFF}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sync, dith_en;
  logic [31:0] freq;
  logic [15:0] phase;
  logic [16:0] cos_o, sin_o;

  tuner_nco u0 (
    .clk(clk), .rst(rst), .sync_i(sync), .freq_i(freq), .phase_i(phase),
    .dith_en_i(dith_en), .cos_o(cos_o), .sin_o(sin_o)
  );

  int n_run = 0, n_fail = 0, hv = 0, mode = 0;
  logic [31:0] acc_m, h0, h1, h2;
  bit done = 0;

  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  function automatic int e_sin(input int i);
    return rnd(AMAX * $sin(6.283185307179586 * (real'(i) + 0.5) / real'(NIDX)));
  endfunction

  function automatic int e_cos(input int i);
    return rnd(AMAX * $cos(6.283185307179586 * (real'(i) + 0.5) / real'(NIDX)));
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(input string tag, input int act, input int expv, input int tol);
    n_run++;
    if (absd(act, expv) > tol) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic check_idx(input string tag, input int idx);
    chk({tag, " cos"}, int'($signed(cos_o)), e_cos(idx), 1);
    chk({tag, " sin"}, int'($signed(sin_o)), e_sin(idx), 1);
  endtask

  task automatic step(input string tag);
    logic [31:0] np;
    int idx, c, s, j;
    bit ok;
    @(posedge clk);
    @(negedge clk);
    np = acc_m + {phase, 16'h0000};
    acc_m = sync ? 32'h0 : acc_m + freq;
    h2 = h1; h1 = h0; h0 = np;
    if (hv < 3) hv++;
    if (mode != 0 && hv >= 3) begin
      idx = int'(h2[31:22]);
      if (mode == 1) check_idx(tag, idx);
      else begin
        c = int'($signed(cos_o));
        s = int'($signed(sin_o));
        j = (idx + 1) % NIDX;
        ok = (absd(c, e_cos(idx)) <= 1 && absd(s, e_sin(idx)) <= 1) ||
             (absd(c, e_cos(j)) <= 1 && absd(s, e_sin(j)) <= 1);
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL R8 actual cos %0d sin %0d expected index %0d or %0d", c, s, idx, j);
        end
        chk("R9 range", (absd(c, 0) > 65535 || absd(s, 0) > 65535) ? 1 : 0, 0, 0);
      end
    end
  endtask

  initial begin
    rst = 1'b1; sync = 1'b0; dith_en = 1'b0; freq = '0; phase = '0;
    acc_m = '0; h0 = '0; h1 = '0; h2 = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    chk("R1 cos in reset", int'($signed(cos_o)), 0, 0);
    chk("R1 sin in reset", int'($signed(sin_o)), 0, 0);
    rst = 1'b0;
    repeat (3) step("R1");
    chk("R1 R4 cos idx0", int'($signed(cos_o)), 65535, 0);
    chk("R1 R4 sin idx0", int'($signed(sin_o)), 201, 0);

    // Vector table: R2 tuning, R3 offset, R4 table values
    mode = 1;
    for (int v = 0; v < NVEC; v++) begin
      freq  = VEC[v][47:16];
      phase = VEC[v][15:0];
      sync  = 1'b1;
      step("R6 sync");
      sync  = 1'b0;
      repeat (24) step("R2,R3,R4 vector");
    end

    // R5: latency of a phase offset change
    mode = 0; freq = '0; phase = '0; sync = 1'b1;
    step("R5"); sync = 1'b0;
    repeat (4) step("R5");
    phase = 16'h4000;
    step("R5"); step("R5");
    chk("R5 cos before latency", int'($signed(cos_o)), 65535, 0);
    step("R5");
    chk("R5 cos after latency", int'($signed(cos_o)), -201, 0);
    chk("R5 sin after latency", int'($signed(sin_o)), 65535, 0);

    // R6: sync restarts the phase and keeps the words
    freq = 32'h0100_0000; phase = '0;
    repeat (10) step("R6");
    sync = 1'b1; step("R6"); sync = 1'b0;
    step("R6"); step("R6"); step("R6");
    check_idx("R6 restart", 0);
    step("R6");
    check_idx("R6 word kept", 4);

    // R7: dither on/off with an offset one dither step below a boundary
    freq = '0; phase = 16'h003F; sync = 1'b1;
    step("R7"); sync = 1'b0;
    repeat (4) step("R7");
    check_idx("R7 dither off", 0);
    dith_en = 1'b1;
    repeat (4) step("R7");
    check_idx("R7 dither on", 1);
    repeat (5) step("R7");
    check_idx("R7 dither on later", 1);
    dith_en = 1'b0;
    repeat (4) step("R7");
    check_idx("R7 dither off again", 0);

    // R8, R9: dithered running tone
    dith_en = 1'b1; freq = 32'h0123_4567; phase = 16'h2000;
    sync = 1'b1; hv = 0; step("R8"); sync = 1'b0;
    mode = 2;
    repeat (40) step("R8");
    freq = 32'hF0F0_F0F1;
    repeat (40) step("R8");
    mode = 0; dith_en = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule